// File: doc/BRIEF.md
# Bus-Clocked Wiper Step Controller

This block drives the fine-tuning mode of a digitally controlled potentiometer array. A byte framer that has just acknowledged the step instruction pulses an entry request together with the channel number. From then on every high pulse of the serial clock moves the selected wiper register by one tap. The level of the serial data line at the clock's rising edge sets the direction: high steps up, toward the high terminal, and low steps down. Steps in both directions may be mixed freely.

The block works from the bus levels after the input filter, sampled in the system clock domain. It finds the clock edges and the bus START and STOP conditions itself. Its output is a one-cycle step-up or step-down strobe together with the channel index, which go to the wiper register file. The file returns the current position of the selected channel, so the block can hold that position at either end of its range. The stored data registers are never touched. A STOP or a repeated START ends the mode.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset `incdec_active`, `step_up` and `step_dn` are 0.
- R2: A one-cycle `incdec_go` makes `incdec_active` 1 on the next clock and loads `step_chan` with `incdec_chan`. Every strobe that follows carries that channel.
- R3: While the mode is active, a serial clock high pulse that rose with data high produces exactly one `step_up` pulse, one system clock wide. It is visible in the cycle after the serial clock is first sampled low, and no other strobe occurs during that pulse.
- R4: The same pulse with data low at the rising edge produces exactly one `step_dn` pulse, with the same timing.
- R5: A data transition while the serial clock is high (a STOP when data rises, a START when data falls) cancels the step of that high pulse and clears `incdec_active` on the next clock.
- R6: No `step_up` is issued when `cur_pos` equals 2^WIPER_W-1, and no `step_dn` is issued when `cur_pos` is 0. There is no wrap-around.
- R7: While `incdec_active` is 0, serial clock pulses produce no strobes.
- R8: A serial clock high phase that was already in progress when the mode was entered produces no step.
- R9: Any number of up and down pulses can be mixed within one active period, and each pulse is handled on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered serial clock level |
| sda_i | input | 1 | Filtered serial data level |
| incdec_go | input | 1 | One-cycle request to enter step mode |
| incdec_chan | input | CH_W | Channel to step, taken with `incdec_go` |
| cur_pos | input | WIPER_W | Current position of channel `step_chan` |
| step_up | output | 1 | One-cycle strobe: add one to the wiper |
| step_dn | output | 1 | One-cycle strobe: subtract one from the wiper |
| step_chan | output | CH_W | Channel that the strobes apply to |
| incdec_active | output | 1 | Step mode is active |

## Verification
The bench builds the block with four channels and a 4-bit wiper. With a 4-bit wiper, both range ends are reached after about a dozen steps, so random up/down runs reach the saturation limits many times, in addition to the directed runs aimed at them. Four channels make mode re-entry to another channel easy to exercise, and a strobe that carries the wrong channel shows up as a mismatch in the bench's register model. Random STOPs and STARTs are mixed into the stepping, and a STOP always follows a clock rise with data low. This exercises the cancelled-step path every time.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } step_dir_e;
endpackage

// File: rtl/wstep_bus_edge.sv
module wstep_bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;
  logic scl_d, sda_d;

  // idle bus is high on both lines
  always_comb begin
    scl_d = scl_i;
    sda_d = sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & ~sda_i & sda_q;
  assign stop_det  = scl_i & scl_q & sda_i & ~sda_q;
endmodule

// File: rtl/wstep_mode_ctl.sv
module wstep_mode_ctl #(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            exit_i,
  output logic            active_o,
  output logic [CH_W-1:0] chan_o
);
  logic            act_q, act_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic            chan_en;

  // an exit condition wins over a simultaneous entry
  always_comb begin
    act_d   = act_q;
    chan_en = enter_i & ~exit_i;
    chan_d  = chan_q;
    if (exit_i)       act_d = 1'b0;
    else if (enter_i) act_d = 1'b1;
    if (chan_en)      chan_d = chan_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      act_q <= act_d;
      if (chan_en) chan_q <= chan_d;
    end
  end

  assign active_o = act_q;
  assign chan_o   = chan_q;

  p_exit_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_i |=> !active_o);

  p_enter_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && !exit_i) |=> (active_o && chan_o == $past(chan_i)));

  p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enter_i |=> $stable(chan_o));
endmodule

// File: rtl/wstep_gen.sv
module wstep_gen
  import wstep_pkg::*;
#(
  parameter int WIPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               bus_cond,
  input  logic               sda_i,
  input  logic [WIPER_W-1:0] cur_pos_i,
  output logic               up_o,
  output logic               dn_o
);
  localparam logic [WIPER_W-1:0] POS_MAX = {WIPER_W{1'b1}};
  localparam logic [WIPER_W-1:0] POS_MIN = '0;

  logic      pend_q, pend_d;
  step_dir_e dir_q, dir_d;
  logic      up_q, up_d, dn_q, dn_d;
  logic      dir_en, fire;

  always_comb begin
    pend_d = pend_q;
    dir_en = 1'b0;
    dir_d  = step_dir_e'(sda_i);
    fire   = scl_fall & pend_q & active_i;
    if (!active_i || bus_cond) begin
      pend_d = 1'b0;
    end else if (scl_rise) begin
      pend_d = 1'b1;
      dir_en = 1'b1;
    end else if (scl_fall) begin
      pend_d = 1'b0;
    end
    up_d = fire && (dir_q == DIR_UP) && (cur_pos_i != POS_MAX);
    dn_d = fire && (dir_q == DIR_DN) && (cur_pos_i != POS_MIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dir_q  <= DIR_DN;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (dir_en) dir_q <= dir_d;
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_o |-> $past(cur_pos_i) != POS_MAX);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_o |-> $past(cur_pos_i) != POS_MIN);

  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  p_single_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_o |=> !up_o);

  p_single_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_o |=> !dn_o);
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl #(
  parameter  int NCH     = 4,
  parameter  int WIPER_W = 8,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               incdec_go,
  input  logic [CH_W-1:0]    incdec_chan,
  input  logic [WIPER_W-1:0] cur_pos,
  output logic               step_up,
  output logic               step_dn,
  output logic [CH_W-1:0]    step_chan,
  output logic               incdec_active
);
  logic scl_rise, scl_fall, start_det, stop_det, bus_cond;

  wstep_bus_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign bus_cond = start_det | stop_det;

  wstep_mode_ctl #(.CH_W(CH_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter_i  (incdec_go),
    .chan_i   (incdec_chan),
    .exit_i   (bus_cond),
    .active_o (incdec_active),
    .chan_o   (step_chan)
  );

  wstep_gen #(.WIPER_W(WIPER_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (incdec_active),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_cond  (bus_cond),
    .sda_i     (sda_i),
    .cur_pos_i (cur_pos),
    .up_o      (step_up),
    .dn_o      (step_dn)
  );

  p_strobe_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> $past(!scl_i));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(incdec_active) |-> !(step_up || step_dn));
endmodule

// File: tb/wiper_step_ctrl_tb.sv
module wiper_step_ctrl_tb;
  localparam int NCH  = 4;
  localparam int WW   = 4;
  localparam int CHW  = 2;
  localparam int MAXV = (1 << WW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, go = 1'b0;
  logic [CHW-1:0] go_ch = '0;
  logic [WW-1:0]  cur_pos;
  logic step_up, step_dn, active;
  logic [CHW-1:0] step_chan;

  logic [WW-1:0] file_pos [NCH];
  int exp_pos [NCH];
  bit m_act = 0;
  int m_ch = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_step_ctrl #(.NCH(NCH), .WIPER_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .incdec_go(go), .incdec_chan(go_ch), .cur_pos(cur_pos),
    .step_up(step_up), .step_dn(step_dn), .step_chan(step_chan),
    .incdec_active(active));

  function automatic int init_pos(int k);
    return (k * 5 + 3) % (MAXV + 1);
  endfunction

  // environment register file driven by the strobes
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) file_pos[k] <= WW'(init_pos(k));
    end else if (step_up) file_pos[step_chan] <= file_pos[step_chan] + 1'b1;
    else if (step_dn) file_pos[step_chan] <= file_pos[step_chan] - 1'b1;
  end
  assign cur_pos = file_pos[step_chan];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter(input int ch);
    @(negedge clk); go = 1'b1; go_ch = CHW'(ch);
    @(negedge clk); go = 1'b0;
    m_act = 1; m_ch = ch;
    chk(active == 1'b1, "R2 active", active, 1);
    chk(int'(step_chan) == ch, "R2 chan", step_chan, ch);
  endtask

  task automatic pulse(input bit d);
    bit eu, ed;
    eu = m_act && d && exp_pos[m_ch] < MAXV;
    ed = m_act && !d && exp_pos[m_ch] > 0;
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = d;
    @(negedge clk); scl = 1'b1;
    repeat (3) @(negedge clk);
    scl = 1'b0;
    @(negedge clk);
    chk(step_up == eu, d ? "R3 up strobe" : "R4 no up", step_up, eu);
    chk(step_dn == ed, d ? "R3 no dn" : "R4 dn strobe", step_dn, ed);
    @(negedge clk);
    chk(!step_up && !step_dn, "R3 one cycle wide", {step_up, step_dn}, 0);
    if (eu) exp_pos[m_ch]++;
    if (ed) exp_pos[m_ch]--;
    for (int k = 0; k < NCH; k++)
      chk(int'(file_pos[k]) == exp_pos[k], "R9 R6 position", file_pos[k], exp_pos[k]);
  endtask

  task automatic bus_stop();
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b1;
    repeat (2) @(negedge clk);
    sda = 1'b1;
    repeat (3) @(negedge clk);
    m_act = 0;
    chk(active == 1'b0, "R5 stop exits", active, 0);
    chk(int'(file_pos[m_ch]) == exp_pos[m_ch], "R5 stop no step", file_pos[m_ch], exp_pos[m_ch]);
  endtask

  task automatic bus_start();
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b1;
    repeat (2) @(negedge clk);
    sda = 1'b0;
    repeat (3) @(negedge clk);
    m_act = 0;
    chk(active == 1'b0, "R5 start exits", active, 0);
    chk(int'(file_pos[m_ch]) == exp_pos[m_ch], "R5 start no step", file_pos[m_ch], exp_pos[m_ch]);
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) exp_pos[k] = init_pos(k);
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(active == 1'b0, "R1 reset active", active, 0);
    chk(!step_up && !step_dn, "R1 reset strobes", {step_up, step_dn}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(active == 1'b0, "R1 after reset", active, 0);
    // R7: idle pulses
    pulse(1'b1); pulse(1'b0);
    // R8: enter while the clock is already high
    @(negedge clk); scl = 1'b1; sda = 1'b0;
    enter(1);
    pulse(1'b1);
    // R6: drive channel 1 to both ends
    for (int i = 0; i < MAXV + 3; i++) pulse(1'b1);
    chk(exp_pos[1] == MAXV, "R6 top reached", exp_pos[1], MAXV);
    for (int i = 0; i < MAXV + 3; i++) pulse(1'b0);
    chk(exp_pos[1] == 0, "R6 bottom reached", exp_pos[1], 0);
    bus_stop();
    pulse(1'b1); // R7 after stop
    enter(3);
    pulse(1'b0); pulse(1'b1); pulse(1'b1);
    bus_start();
    pulse(1'b0); // R7 after start
    // random mix
    enter(0);
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) begin bus_stop(); enter($urandom % NCH); end
      else if (r == 1) begin bus_start(); enter($urandom % NCH); end
      else if (r == 2) enter($urandom % NCH);
      else pulse(1'($urandom % 2));
    end
    bus_stop();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule